// File: doc/BRIEF.md
# Serial Port with Sticky Event Interrupts

This block is a byte-wide serial port that sits behind a simple 32-bit register bus. A byte written to the data register is sent on the transmit line as one start bit, eight data bits (least significant first) and one stop bit. A programmable divisor sets how many clock cycles each bit lasts. The receiver watches the receive line for a start bit. It samples every bit at the middle of its period and places the byte in a one-byte holding register.

Two sticky event flags, one for receive and one for transmit, record that a byte arrived or that a character finished leaving the port. Software clears each flag by writing a one to its bit. An enable bit per event gates that flag onto one level-sensitive interrupt line. While the receive flag is still set, the port refuses to overwrite the holding register, so software must clear the flag before the next byte can be kept. Two further control bits, a pass-through enable and a break enable, are only stored.

Top module: `sticky_evt_uart`

## Requirements
- R1: After reset the data, divisor, control and debug registers read 0, the status register reads 0x1, the transmit line is high and the interrupt is low.
- R2: Registers sit at byte offsets 0x00 data, 0x04 divisor (low DIV_W bits kept), 0x08 status, 0x0C control (bits 2:0 kept) and 0x10 debug (bit 0 kept); unkept bits read 0. A read from any other offset returns 0 and a write to it changes nothing. A write whose byte enables are not all four set is ignored.
- R3: Status bit 0 (transmit holding empty) always reads 1. Writing status clears bit 1 (receive event) and bit 2 (transmit event) where the written bit is 1. Written zeros leave the flags unchanged.
- R4: The interrupt equals (status bit 1 AND control bit 0) OR (status bit 2 AND control bit 1) at all times.
- R5: A data write while idle sends its low byte in the cycle after the write. The frame is a low start bit, data bits LSB first, then a high stop bit, and each bit lasts divisor+1 clock cycles (the divisor value at the time of the write). The line rests high.
- R6: The transmit event flag is set at the clock edge that ends the stop bit, the same edge on which the line returns to idle, and not at the data write.
- R7: A data write while a character is being sent is ignored: the frame in progress is unchanged and no extra character follows.
- R8: A received byte (low start, 8 data LSB first, high stop, each divisor+1 cycles) that arrives while the receive flag is clear is stored and sets the receive flag. Reading offset 0x00 returns it in bits 7:0.
- R9: A byte that completes while the receive flag is set is dropped: the held byte and flag stay as they were.
- R10: A low pulse on the receive line that is high again at the middle of the start bit is discarded and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_be | input | 4 | Byte enables; writes need all four |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
Transmission is tried with two byte patterns, an alternating-nibble value and a single set bit. The reference model predicts the transmit line on every clock, which separates bit order, bit length and frame end. A data write in the middle of a frame shows whether a busy write is ignored or restarts the shifter. Reception is tried with a clean byte, a second byte while the flag is still set (hold-off against overwrite), a byte after clearing, and a two-cycle glitch (start validation). Interrupt checks with each enable off and on show whether the event flags are gated correctly.

// File: rtl/sevu_pkg.sv
package sevu_pkg;
   localparam logic [7:0] OFF_DATA = 8'h00;
   localparam logic [7:0] OFF_DIV  = 8'h04;
   localparam logic [7:0] OFF_STAT = 8'h08;
   localparam logic [7:0] OFF_CTRL = 8'h0C;
   localparam logic [7:0] OFF_DBG  = 8'h10;

   localparam int ST_THRE = 0;
   localparam int ST_RXEV = 1;
   localparam int ST_TXEV = 2;
   localparam int CT_RXIE = 0;
   localparam int CT_TXIE = 1;
   localparam int CT_W    = 3;

   localparam int FRAME_BITS = 10;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP
   } rx_state_e;
endpackage

// File: rtl/sevu_tx.sv
module sevu_tx #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [7:0]       data_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             txd_o
);
   import sevu_pkg::*;
   localparam int BIT_W = $clog2(FRAME_BITS);

   logic                  busy_q;
   logic [FRAME_BITS-1:0] shreg_q;
   logic [BIT_W-1:0]      bit_q;
   logic [DIV_W-1:0]      cnt_q;
   logic [DIV_W-1:0]      per_q;
   logic                  tick;

   assign tick   = busy_q && (cnt_q == per_q);
   assign done_o = tick && (bit_q == BIT_W'(FRAME_BITS-1));
   assign busy_o = busy_q;
   assign txd_o  = busy_q ? shreg_q[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         shreg_q <= '1;
         bit_q   <= '0;
         cnt_q   <= '0;
         per_q   <= '0;
      end else if (!busy_q) begin
         if (start_i) begin
            busy_q  <= 1'b1;
            shreg_q <= {1'b1, data_i, 1'b0};
            bit_q   <= '0;
            cnt_q   <= '0;
            per_q   <= div_i;
         end
      end else if (tick) begin
         cnt_q   <= '0;
         shreg_q <= {1'b1, shreg_q[FRAME_BITS-1:1]};
         if (bit_q == BIT_W'(FRAME_BITS-1)) busy_q <= 1'b0;
         else                               bit_q  <= bit_q + 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> !txd_o); // R5
   AST_TX_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!busy_o && txd_o)); // R6
   AST_TX_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_i && !done_o) |=> (busy_q && $stable(per_q))); // R7
endmodule

// File: rtl/sevu_rx.sv
module sevu_rx #(
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rxd_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             valid_o,
   output logic [7:0]       byte_o
);
   import sevu_pkg::*;

   logic rx_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_s = rxd_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sq;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sq <= '1;
         else        sq <= SYNC_STAGES'({sq, rxd_i});
      end
      assign rx_s = sq[SYNC_STAGES-1];
   end

   rx_state_e        st_q;
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] per_q;
   logic [2:0]       bit_q;
   logic [7:0]       sh_q;
   logic             valid_q;

   assign valid_o = valid_q;
   assign byte_o  = sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= RX_IDLE;
         cnt_q   <= '0;
         per_q   <= '0;
         bit_q   <= '0;
         sh_q    <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         case (st_q)
            RX_IDLE: if (!rx_s) begin
               st_q  <= RX_START;
               cnt_q <= '0;
               per_q <= div_i;
            end
            RX_START: if (cnt_q == (per_q >> 1)) begin
               cnt_q <= '0;
               bit_q <= '0;
               st_q  <= rx_s ? RX_IDLE : RX_DATA;
            end else cnt_q <= cnt_q + 1'b1;
            RX_DATA: if (cnt_q == per_q) begin
               cnt_q <= '0;
               sh_q  <= {rx_s, sh_q[7:1]};
               if (bit_q == 3'd7) st_q  <= RX_STOP;
               else               bit_q <= bit_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
            default: if (cnt_q == per_q) begin
               st_q    <= RX_IDLE;
               valid_q <= rx_s;
            end else cnt_q <= cnt_q + 1'b1;
         endcase
      end
   end

   AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o); // R8
   AST_RX_IDLE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (st_q == RX_IDLE)); // R10
endmodule

// File: rtl/sticky_evt_uart.sv
module sticky_evt_uart #(
   parameter int ADDR_W      = 5,
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_be,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic              txd,
   input  logic              rxd
);
   import sevu_pkg::*;

   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must reach offset 0x10");
   end
   if (DIV_W < 2 || DIV_W > 32) begin : g_bad_div
      $error("DIV_W must be in 2..32");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be in 0..4");
   end

   logic sel_data, sel_div, sel_stat, sel_ctrl, sel_dbg;
   assign sel_data = (bus_addr == ADDR_W'(OFF_DATA));
   assign sel_div  = (bus_addr == ADDR_W'(OFF_DIV));
   assign sel_stat = (bus_addr == ADDR_W'(OFF_STAT));
   assign sel_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
   assign sel_dbg  = (bus_addr == ADDR_W'(OFF_DBG));

   logic wr_ok;
   assign wr_ok = bus_wr && (bus_be == 4'hF);

   logic [DIV_W-1:0] div_q;
   logic [CT_W-1:0]  ctrl_q;
   logic             dbg_q;
   logic             rx_evt_q, tx_evt_q;
   logic [7:0]       rx_byte_q;

   logic             tx_busy, tx_done;
   logic             rx_valid;
   logic [7:0]       rx_byte;
   logic             clr_rx, clr_tx;
   logic             unused_wbits;

   assign unused_wbits = ^bus_wdata;
   assign clr_rx = wr_ok && sel_stat && bus_wdata[ST_RXEV];
   assign clr_tx = wr_ok && sel_stat && bus_wdata[ST_TXEV];

   sevu_tx #(.DIV_W(DIV_W)) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(wr_ok && sel_data),
      .data_i (bus_wdata[7:0]),
      .div_i  (div_q),
      .busy_o (tx_busy),
      .done_o (tx_done),
      .txd_o  (txd)
   );

   sevu_rx #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .rxd_i  (rxd),
      .div_i  (div_q),
      .valid_o(rx_valid),
      .byte_o (rx_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q     <= '0;
         ctrl_q    <= '0;
         dbg_q     <= 1'b0;
         rx_evt_q  <= 1'b0;
         tx_evt_q  <= 1'b0;
         rx_byte_q <= '0;
      end else begin
         if (wr_ok && sel_div)  div_q  <= bus_wdata[DIV_W-1:0];
         if (wr_ok && sel_ctrl) ctrl_q <= bus_wdata[CT_W-1:0];
         if (wr_ok && sel_dbg)  dbg_q  <= bus_wdata[0];
         if (rx_evt_q) begin
            if (clr_rx) rx_evt_q <= 1'b0;
         end else if (rx_valid) begin
            rx_evt_q  <= 1'b1;
            rx_byte_q <= rx_byte;
         end
         if (tx_done)     tx_evt_q <= 1'b1;
         else if (clr_tx) tx_evt_q <= 1'b0;
      end
   end

   assign irq = (rx_evt_q && ctrl_q[CT_RXIE]) || (tx_evt_q && ctrl_q[CT_TXIE]);

   always_comb begin
      bus_rdata = '0;
      if (sel_data)      bus_rdata = 32'(rx_byte_q);
      else if (sel_div)  bus_rdata = 32'(div_q);
      else if (sel_stat) bus_rdata = 32'({tx_evt_q, rx_evt_q, 1'b1});
      else if (sel_ctrl) bus_rdata = 32'(ctrl_q);
      else if (sel_dbg)  bus_rdata = 32'(dbg_q);
   end

   AST_RX_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_evt_q && !clr_rx) |=> rx_evt_q); // R3
   AST_IRQ_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (rx_evt_q || tx_evt_q)); // R4
   AST_TXEV_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_evt_q) |-> $past(tx_busy)); // R6
   AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_evt_q |=> $stable(rx_byte_q)); // R9
endmodule

// File: tb/sticky_evt_uart_bench.sv
module sticky_evt_uart_bench;
   localparam int DIV = 15;
   localparam int PER = DIV + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, txd;
   logic        rxd = 1'b1;

   int n_cmp = 0;
   int n_bad = 0;

   // reference model state
   int m_div = 0, m_ctrl = 0, m_dbg = 0;
   int m_rxevt = 0, m_txevt = 0, m_rxbyte = 0;
   int m_tx_act = 0, m_tx_cyc = 0, m_tx_byte = 0, m_tx_per = 1;
   logic rx_mask = 1'b0;
   logic rx_arrive = 1'b0;
   int   rx_in = 0;

   always #10 clk = ~clk;

   sticky_evt_uart u_sticky_evt_uart (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .txd(txd), .rxd(rxd)
   );

   always @(posedge clk) begin
      if (rst_n) begin
         int act0;
         act0 = m_tx_act;
         if (bus_wr && bus_be == 4'hF && bus_addr == 5'h08) begin
            if (bus_wdata[1]) m_rxevt = 0;
            if (bus_wdata[2]) m_txevt = 0;
         end
         if (m_tx_act != 0) begin
            m_tx_cyc = m_tx_cyc + 1;
            if (m_tx_cyc == 10 * m_tx_per) begin
               m_tx_act = 0;
               m_txevt = 1;
            end
         end
         if (bus_wr && bus_be == 4'hF) begin
            case (bus_addr)
               5'h00: if (act0 == 0) begin
                  m_tx_act = 1; m_tx_cyc = 0;
                  m_tx_byte = int'(bus_wdata[7:0]); m_tx_per = m_div + 1;
               end
               5'h04: m_div = int'(bus_wdata[15:0]);
               5'h0C: m_ctrl = int'(bus_wdata[2:0]);
               5'h10: m_dbg = int'(bus_wdata[0]);
               default: ;
            endcase
         end
         if (rx_arrive && m_rxevt == 0) begin
            m_rxevt = 1;
            m_rxbyte = rx_in;
         end
      end
   end

   function automatic logic exp_txd();
      int bi;
      if (m_tx_act == 0) return 1'b1;
      bi = m_tx_cyc / m_tx_per;
      if (bi == 0) return 1'b0;
      if (bi >= 9) return 1'b1;
      return logic'((m_tx_byte >> (bi - 1)) & 1);
   endfunction

   function automatic logic exp_irq();
      return ((m_rxevt != 0) && (m_ctrl & 1) != 0) || ((m_txevt != 0) && (m_ctrl & 2) != 0);
   endfunction

   // every-clock comparison of serial output and interrupt
   always @(negedge clk) begin
      if (rst_n) begin
         n_cmp++;
         if (txd !== exp_txd()) begin
            n_bad++;
            $display("FAIL R5 txd actual %b expected %b at %0t", txd, exp_txd(), $time);
         end
         if (!rx_mask) begin
            n_cmp++;
            if (irq !== exp_irq()) begin
               n_bad++;
               $display("FAIL R4 irq actual %b expected %b at %0t", irq, exp_irq(), $time);
            end
         end
      end
   end

   task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a;
      #2;
      n_cmp++;
      if (bus_rdata !== exp) begin
         n_bad++;
         $display("FAIL %s read 0x%0h actual 0x%0h expected 0x%0h", tag, a, bus_rdata, exp);
      end
   endtask

   task automatic chk_bit(input logic act, input logic exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic send_rx(input logic [7:0] b);
      rx_mask = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         rxd = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : b[i-1];
         repeat (PER - 1) @(negedge clk);
      end
      repeat (3) @(negedge clk);
      rx_in = int'(b);
      rx_arrive = 1'b1;
      @(negedge clk);
      rx_arrive = 1'b0;
      rx_mask = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(5'h00, 32'h0, "R1"); rd(5'h04, 32'h0, "R1"); rd(5'h08, 32'h1, "R1");
      rd(5'h0C, 32'h0, "R1"); rd(5'h10, 32'h0, "R1");
      chk_bit(txd, 1'b1, "R1 txd"); chk_bit(irq, 1'b0, "R1 irq");
      // R2 register map
      wr(5'h04, 32'h0001_2345, 4'hF); rd(5'h04, 32'h2345, "R2");
      wr(5'h04, DIV, 4'hF);           rd(5'h04, DIV, "R2");
      wr(5'h04, 32'h3, 4'h3);         rd(5'h04, DIV, "R2 partial");
      wr(5'h0C, 32'hFFFF_FFF8, 4'hF); rd(5'h0C, 32'h0, "R2");
      wr(5'h10, 32'hFFFF, 4'hF);      rd(5'h10, 32'h1, "R2");
      wr(5'h14, 32'h5, 4'hF);         rd(5'h14, 32'h0, "R2 unmapped");
      rd(5'h04, DIV, "R2 unmapped"); rd(5'h10, 32'h1, "R2 unmapped");
      // R3 thre fixed
      wr(5'h08, 32'hFFFF_FFFF, 4'hF); rd(5'h08, 32'h1, "R3");
      // R5 R6 frame with tx irq enabled
      wr(5'h0C, 32'h2, 4'hF);
      wr(5'h00, 32'hA5, 4'hF);
      rd(5'h08, 32'h1, "R6 not at write");
      repeat (50) @(negedge clk);
      wr(5'h00, 32'h3C, 4'hF); // R7 busy write
      repeat (130) @(negedge clk);
      rd(5'h08, 32'h5, "R6"); chk_bit(irq, 1'b1, "R4 tx");
      repeat (20) @(negedge clk);
      chk_bit(txd, 1'b1, "R7 no extra frame");
      wr(5'h08, 32'h4, 4'hF); rd(5'h08, 32'h1, "R3 clear tx");
      chk_bit(irq, 1'b0, "R4");
      // second pattern with irq disabled
      wr(5'h0C, 32'h0, 4'hF);
      wr(5'h00, 32'h01, 4'hF);
      repeat (PER * 10 + 5) @(negedge clk);
      rd(5'h08, 32'h5, "R6"); chk_bit(irq, 1'b0, "R4 gated");
      wr(5'h0C, 32'h2, 4'hF); chk_bit(irq, 1'b1, "R4 enabled");
      wr(5'h08, 32'h4, 4'hF);
      // R8 receive
      wr(5'h0C, 32'h1, 4'hF);
      send_rx(8'h5A);
      rd(5'h00, 32'h5A, "R8"); rd(5'h08, 32'h3, "R8"); chk_bit(irq, 1'b1, "R4 rx");
      wr(5'h08, 32'h0, 4'hF); rd(5'h08, 32'h3, "R3 zeros");
      // R9 hold-off
      send_rx(8'hC3);
      rd(5'h00, 32'h5A, "R9");
      wr(5'h08, 32'h2, 4'hF); rd(5'h08, 32'h1, "R3 clear rx");
      send_rx(8'hC3);
      rd(5'h00, 32'hC3, "R9 after clear");
      wr(5'h08, 32'h2, 4'hF);
      // R10 glitch
      rx_mask = 1'b1;
      @(negedge clk); rxd = 1'b0;
      repeat (2) @(negedge clk); rxd = 1'b1;
      repeat (PER * 3) @(negedge clk);
      rx_mask = 1'b0;
      rd(5'h08, 32'h1, "R10"); rd(5'h00, 32'hC3, "R10");
      repeat (5) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule